// File: doc/BRIEF.md
# Maskable interrupt priority resolver

This block is the decision core of an eight-input interrupt controller. It captures request lines into a pending register, holds a per-level mask and an in-service register, and chooses the pending, unmasked level of highest priority. When that level outranks every level that currently blocks it, the block raises its interrupt output. A separate acknowledge sequencer reads back the winning level and sends the block two strobes. The first strobe grants the winner. The last strobe ends the handshake and is used for automatic end-of-interrupt.

Priority is circular. A pointer names the lowest-priority level, and the level just above it in wrap-around order is the highest. End-of-interrupt, rotation and set-priority commands arrive already decoded as a 3-bit code with a 3-bit level field. Special mask mode is switched by an enable/set strobe pair. Two static configuration inputs come from the initialisation logic elsewhere: the capture style (edge or level) and automatic end-of-interrupt. The pending and in-service registers are brought out so that the register read path can return them.

Top module: `irq_prio_core`

## Requirements
- R1: With `level_mode_i`=0, a request line is synchronised and its rising edge sets its pending bit, which stays set until granted even while the line stays high. With `level_mode_i`=1, `irr_o` follows `irq_i` one clock later.
- R2: When `ack_first_i` is high while `irq_o` is high, the in-service bit of level `ack_level_o` is set and that pending bit is cleared. No new request is captured into the pending register in that cycle.
- R3: A mask bit at 1 (written through `mask_wr_i`/`mask_data_i`, bit n for level n) keeps level n from asserting `irq_o`. With nothing in service and all lines pending, `irq_o` is high exactly when some mask bit is 0.
- R4: After reset, `irr_o`, `isr_o`, the mask and special mask mode are all 0, `irq_o` is low, and the lowest-priority level is 7, so that level 0 is the highest.
- R5: `irq_o` is high only when the winning request strictly outranks every blocking in-service level. A level in service blocks requests at its own level and at lower levels.
- R6: Code `cmd_code_i` = {R,SL,EOI} = 001 clears the highest-priority in-service bit. Code 011 clears the in-service bit of `cmd_level_i`, where the values 0 to 7 name levels 0 to 7.
- R7: Code 101 clears the highest-priority in-service bit and makes that level the lowest priority. Code 111 clears bit `cmd_level_i` and makes that level the lowest. Code 110 only makes `cmd_level_i` the lowest.
- R8: With `auto_eoi_i`=1, `ack_last_i` clears the in-service bit of the level last granted. Code 100 sets, and code 000 clears, a flag that makes that level the lowest priority at this point.
- R9: `smm_enable_i`=1 with `smm_set_i`=1 turns special mask mode on, and with `smm_set_i`=0 turns it off. `smm_enable_i`=0 has no effect. While the mode is on, only in-service levels that are not masked block requests.
- R10: Code 010 changes neither the in-service register nor the priority order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | 8 | Request lines, one per level |
| level_mode_i | input | 1 | 1 = level capture, 0 = rising-edge capture |
| auto_eoi_i | input | 1 | 1 = in-service bit cleared by the last acknowledge strobe |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 8 | New mask value, bit n masks level n |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code {R,SL,EOI} |
| cmd_level_i | input | 3 | Level operand of specific commands |
| smm_enable_i | input | 1 | Special mask mode change enable |
| smm_set_i | input | 1 | Special mask mode new value |
| ack_first_i | input | 1 | First acknowledge strobe (grant) |
| ack_last_i | input | 1 | Last acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_level_o | output | 3 | Winning level for the acknowledge sequencer |
| irr_o | output | 8 | Pending request register |
| isr_o | output | 8 | In-service register |

## Verification
The hardest state to reach is one in which a masked in-service level is the only thing that holds back a lower-priority pending request. This state shows whether special mask mode lets the request through. The bench builds it by granting level 3 and then raising level 5. It then masks level 3 and checks that the interrupt stays low in normal mode, rises when the mode is switched on, stays up after an enable-less strobe, and falls when the mode is switched off. The rotation states are reached in a similar way: a grant followed by a rotating end-of-interrupt, or an automatic end-of-interrupt with the rotate flag set. In each case the new order is read from `ack_level_o` with every line pending.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Decoded command codes, packed as {R, SL, EOI}
  typedef enum logic [2:0] {
    CMD_CLR_ROT_AEOI = 3'b000,
    CMD_NS_EOI       = 3'b001,
    CMD_NOP          = 3'b010,
    CMD_SP_EOI       = 3'b011,
    CMD_SET_ROT_AEOI = 3'b100,
    CMD_ROT_NS_EOI   = 3'b101,
    CMD_SET_PRIO     = 3'b110,
    CMD_ROT_SP_EOI   = 3'b111
  } cmd_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic               freeze_i,
  input  logic               clr_en_i,
  input  logic [LVL_W-1:0]   clr_lvl_i,
  output logic [NUM_LVL-1:0] irr_o
);

  logic [NUM_LVL-1:0] sync0_q, sync1_q, prev_q, irr_q;
  logic [NUM_LVL-1:0] prev_n, irr_n, rise, clr_vec;

  always_comb begin
    rise    = sync1_q & ~prev_q;
    clr_vec = clr_en_i ? (NUM_LVL'(1) << clr_lvl_i) : '0;
    // edge history is held while frozen so an edge is not lost
    prev_n  = freeze_i ? prev_q : sync1_q;
    if (freeze_i)          irr_n = irr_q & ~clr_vec;
    else if (level_mode_i) irr_n = irq_i;
    else                   irr_n = irr_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q <= '0;
      sync1_q <= '0;
      prev_q  <= '0;
      irr_q   <= '0;
    end else begin
      sync0_q <= irq_i;
      sync1_q <= sync0_q;
      prev_q  <= prev_n;
      irr_q   <= irr_n;
    end
  end

  assign irr_o = irr_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic [NUM_LVL-1:0] vec_i,
  input  logic [LVL_W-1:0]   lowest_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o
);

  logic [LVL_W-1:0] idx;

  // Walk from lowest to highest priority; the last hit wins.
  always_comb begin
    any_o = 1'b0;
    lvl_o = '0;
    idx   = '0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      idx = lowest_i + LVL_W'(k + 1);
      if (vec_i[idx]) begin
        any_o = 1'b1;
        lvl_o = idx;
      end
    end
  end

endmodule

// File: rtl/irq_service_ctl.sv
module irq_service_ctl
  import irq_prio_pkg::*;
#(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_eoi_i,
  input  logic               grant_i,
  input  logic [LVL_W-1:0]   win_lvl_i,
  input  logic               ack_last_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_level_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LVL-1:0] mask_data_i,
  input  logic               smm_enable_i,
  input  logic               smm_set_i,
  input  logic               top_any_i,
  input  logic [LVL_W-1:0]   top_lvl_i,
  output logic [NUM_LVL-1:0] isr_o,
  output logic [NUM_LVL-1:0] mask_o,
  output logic               smm_o,
  output logic [LVL_W-1:0]   ptr_o
);

  logic [NUM_LVL-1:0] isr_q, isr_n, mask_q, mask_n;
  logic [LVL_W-1:0]   ptr_q, ptr_n, svc_q, svc_n;
  logic               smm_q, smm_n, rot_q, rot_n;

  always_comb begin
    isr_n  = isr_q;
    mask_n = mask_q;
    ptr_n  = ptr_q;
    svc_n  = svc_q;
    smm_n  = smm_q;
    rot_n  = rot_q;

    if (grant_i) begin
      isr_n[win_lvl_i] = 1'b1;
      svc_n            = win_lvl_i;
    end

    if (ack_last_i && auto_eoi_i) begin
      isr_n[svc_q] = 1'b0;
      if (rot_q) ptr_n = svc_q;
    end

    if (mask_wr_i)    mask_n = mask_data_i;
    if (smm_enable_i) smm_n  = smm_set_i;

    if (cmd_valid_i) begin
      case (cmd_code_i)
        CMD_NS_EOI: begin
          if (top_any_i) isr_n[top_lvl_i] = 1'b0;
        end
        CMD_SP_EOI: begin
          isr_n[cmd_level_i] = 1'b0;
        end
        CMD_ROT_NS_EOI: begin
          if (top_any_i) begin
            isr_n[top_lvl_i] = 1'b0;
            ptr_n            = top_lvl_i;
          end
        end
        CMD_ROT_SP_EOI: begin
          isr_n[cmd_level_i] = 1'b0;
          ptr_n              = cmd_level_i;
        end
        CMD_SET_PRIO:     ptr_n = cmd_level_i;
        CMD_SET_ROT_AEOI: rot_n = 1'b1;
        CMD_CLR_ROT_AEOI: rot_n = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      mask_q <= '0;
      ptr_q  <= LVL_W'(NUM_LVL - 1);
      svc_q  <= '0;
      smm_q  <= 1'b0;
      rot_q  <= 1'b0;
    end else begin
      isr_q  <= isr_n;
      mask_q <= mask_n;
      ptr_q  <= ptr_n;
      svc_q  <= svc_n;
      smm_q  <= smm_n;
      rot_q  <= rot_n;
    end
  end

  assign isr_o  = isr_q;
  assign mask_o = mask_q;
  assign smm_o  = smm_q;
  assign ptr_o  = ptr_q;

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               level_mode_i,
  input  logic               auto_eoi_i,
  input  logic               mask_wr_i,
  input  logic [NUM_LVL-1:0] mask_data_i,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_code_i,
  input  logic [LVL_W-1:0]   cmd_level_i,
  input  logic               smm_enable_i,
  input  logic               smm_set_i,
  input  logic               ack_first_i,
  input  logic               ack_last_i,
  output logic               irq_o,
  output logic [LVL_W-1:0]   ack_level_o,
  output logic [NUM_LVL-1:0] irr_o,
  output logic [NUM_LVL-1:0] isr_o
);

  localparam int NUM_PICK = 3;  // request, blocking, full in-service

  logic                 rst_meta_q, rst_sync_n;
  logic [NUM_LVL-1:0]   irr_q, isr_q, mask_q, blk_vec;
  logic                 smm_q, grant;
  logic [LVL_W-1:0]     ptr_q, req_rank, blk_rank;
  logic [NUM_PICK-1:0]  pick_any;
  logic [LVL_W-1:0]     pick_lvl [NUM_PICK];
  logic [NUM_LVL-1:0]   pick_vec [NUM_PICK];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  irq_req_capture #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .irq_i        (irq_i),
    .level_mode_i (level_mode_i),
    .freeze_i     (ack_first_i),
    .clr_en_i     (grant),
    .clr_lvl_i    (pick_lvl[0]),
    .irr_o        (irr_q)
  );

  always_comb begin
    blk_vec     = smm_q ? (isr_q & ~mask_q) : isr_q;
    pick_vec[0] = irr_q & ~mask_q;
    pick_vec[1] = blk_vec;
    pick_vec[2] = isr_q;
  end

  for (genvar g = 0; g < NUM_PICK; g++) begin : g_pick
    irq_prio_pick #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_pick (
      .vec_i    (pick_vec[g]),
      .lowest_i (ptr_q),
      .any_o    (pick_any[g]),
      .lvl_o    (pick_lvl[g])
    );
  end

  // rank 0 = highest priority
  always_comb begin
    req_rank = pick_lvl[0] - ptr_q - LVL_W'(1);
    blk_rank = pick_lvl[1] - ptr_q - LVL_W'(1);
    irq_o    = pick_any[0] && (!pick_any[1] || (req_rank < blk_rank));
    grant    = ack_first_i && irq_o;
  end

  irq_service_ctl #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_service (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .auto_eoi_i   (auto_eoi_i),
    .grant_i      (grant),
    .win_lvl_i    (pick_lvl[0]),
    .ack_last_i   (ack_last_i),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_code_i   (cmd_code_i),
    .cmd_level_i  (cmd_level_i),
    .mask_wr_i    (mask_wr_i),
    .mask_data_i  (mask_data_i),
    .smm_enable_i (smm_enable_i),
    .smm_set_i    (smm_set_i),
    .top_any_i    (pick_any[2]),
    .top_lvl_i    (pick_lvl[2]),
    .isr_o        (isr_q),
    .mask_o       (mask_q),
    .smm_o        (smm_q),
    .ptr_o        (ptr_q)
  );

  assign ack_level_o = pick_lvl[0];
  assign irr_o       = irr_q;
  assign isr_o       = isr_q;

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               ack_first_i,
  input logic               ack_last_i,
  input logic               auto_eoi_i,
  input logic               cmd_valid_i,
  input logic [2:0]         cmd_code_i,
  input logic [LVL_W-1:0]   cmd_level_i,
  input logic               irq_o,
  input logic [LVL_W-1:0]   ack_level_o,
  input logic [NUM_LVL-1:0] irr_o,
  input logic [NUM_LVL-1:0] isr_o,
  input logic [NUM_LVL-1:0] mask_q,
  input logic               smm_q
);

  assert_irq_has_pending_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> irr_o[ack_level_o]);

  assert_grant_sets_isr_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_first_i && irq_o && !cmd_valid_i && !ack_last_i) |=> isr_o[$past(ack_level_o)]);

  assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> !mask_q[ack_level_o]);

  assert_equal_level_blocked_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_o && !smm_q) |-> !isr_o[ack_level_o]);

  assert_specific_eoi_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_code_i == 3'b011 && !ack_first_i) |=> !isr_o[$past(cmd_level_i)]);

  assert_aeoi_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_last_i && auto_eoi_i && !ack_first_i && !cmd_valid_i)
      |=> ($countones(isr_o) <= $countones($past(isr_o))));

  assert_nop_keeps_isr_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid_i && cmd_code_i == 3'b010 && !ack_first_i && !ack_last_i) |=> $stable(isr_o));

endmodule

bind irq_prio_core irq_prio_checker #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .ack_first_i (ack_first_i),
  .ack_last_i  (ack_last_i),
  .auto_eoi_i  (auto_eoi_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_code_i  (cmd_code_i),
  .cmd_level_i (cmd_level_i),
  .irq_o       (irq_o),
  .ack_level_o (ack_level_o),
  .irr_o       (irr_o),
  .isr_o       (isr_o),
  .mask_q      (mask_q),
  .smm_q       (smm_q)
);

// File: tb/irq_prio_core_bench.sv
`timescale 1ns/1ps
module irq_prio_core_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_i;
  logic       level_mode_i, auto_eoi_i, mask_wr_i;
  logic [7:0] mask_data_i;
  logic       cmd_valid_i;
  logic [2:0] cmd_code_i, cmd_level_i;
  logic       smm_enable_i, smm_set_i, ack_first_i, ack_last_i;
  logic       irq_o;
  logic [2:0] ack_level_o;
  logic [7:0] irr_o, isr_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  irq_prio_core u_irq_prio_core (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .level_mode_i(level_mode_i),
    .auto_eoi_i(auto_eoi_i), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
    .cmd_valid_i(cmd_valid_i), .cmd_code_i(cmd_code_i), .cmd_level_i(cmd_level_i),
    .smm_enable_i(smm_enable_i), .smm_set_i(smm_set_i), .ack_first_i(ack_first_i),
    .ack_last_i(ack_last_i), .irq_o(irq_o), .ack_level_o(ack_level_o),
    .irr_o(irr_o), .isr_o(isr_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] code, input logic [2:0] lvl);
    cmd_valid_i = 1'b1; cmd_code_i = code; cmd_level_i = lvl;
    tick();
    cmd_valid_i = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] m);
    mask_wr_i = 1'b1; mask_data_i = m;
    tick();
    mask_wr_i = 1'b0;
  endtask

  task automatic ack_first();
    ack_first_i = 1'b1; tick(); ack_first_i = 1'b0;
  endtask

  task automatic ack_last();
    ack_last_i = 1'b1; tick(); ack_last_i = 1'b0;
  endtask

  task automatic smm(input logic en, input logic st);
    smm_enable_i = en; smm_set_i = st; tick(); smm_enable_i = 1'b0; smm_set_i = 1'b0;
  endtask

  task automatic irq_lvl(input logic [7:0] v);
    irq_i = v; tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; irq_i = '0; level_mode_i = 1'b0; auto_eoi_i = 1'b0;
    mask_wr_i = 1'b0; mask_data_i = '0; cmd_valid_i = 1'b0; cmd_code_i = '0;
    cmd_level_i = '0; smm_enable_i = 1'b0; smm_set_i = 1'b0;
    ack_first_i = 1'b0; ack_last_i = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R4 reset state
    chk({7'd0, irq_o}, 8'h00, "R4 irq_o after reset");
    chk(irr_o, 8'h00, "R4 irr after reset");
    chk(isr_o, 8'h00, "R4 isr after reset");

    // R1 edge capture
    irq_i = 8'h04; tick(4);
    chk(irr_o, 8'h04, "R1 edge sets pending");
    chk({5'd0, ack_level_o}, 8'd2, "R1 edge winner level");
    ack_first();
    chk(isr_o, 8'h04, "R2 grant sets in-service");
    chk(irr_o, 8'h00, "R2 grant clears pending");
    tick(3);
    chk(irr_o, 8'h00, "R1 held line gives no new edge");
    irq_i = 8'h00; tick(3);
    irq_i = 8'h04; tick(4);
    chk(irr_o, 8'h04, "R1 second edge captured");
    chk({7'd0, irq_o}, 8'h00, "R5 equal level in service blocks");
    cmd(3'b001, 3'd0);
    chk(isr_o, 8'h00, "R6 non-specific eoi clears");
    chk({7'd0, irq_o}, 8'h01, "R5 request after eoi");

    // R1 level capture
    level_mode_i = 1'b1; irq_i = 8'h00; tick();
    chk(irr_o, 8'h00, "R1 level follows low");
    irq_lvl(8'h24);
    chk(irr_o, 8'h24, "R1 level follows pattern");
    irq_lvl(8'h00);
    chk(irr_o, 8'h00, "R1 level release");

    // R3 mask sweep, default order (R4: level 0 highest)
    irq_lvl(8'hFF);
    for (int m = 0; m < 256; m++) begin
      int expl;
      expl = 0;
      for (int b = 7; b >= 0; b--) if (!m[b]) expl = b;
      set_mask(8'(m));
      chk({7'd0, irq_o}, (m != 255) ? 8'h01 : 8'h00, "R3 mask gates irq");
      if (m != 255) chk({5'd0, ack_level_o}, 8'(expl), "R4 R3 highest unmasked");
    end
    set_mask(8'h00);

    // R7 set priority sweep
    for (int l = 0; l < 8; l++) begin
      cmd(3'b110, 3'(l));
      chk({5'd0, ack_level_o}, 8'((l + 1) % 8), "R7 set priority order");
    end
    cmd(3'b110, 3'd7);

    // R5 R6 nesting
    irq_lvl(8'h08);
    chk({5'd0, ack_level_o}, 8'd3, "R5 single request level");
    ack_first();
    chk(isr_o, 8'h08, "R2 level 3 in service");
    irq_lvl(8'h28);
    chk({7'd0, irq_o}, 8'h00, "R5 lower level blocked");
    irq_lvl(8'h2A);
    chk({7'd0, irq_o}, 8'h01, "R5 higher level interrupts");
    chk({5'd0, ack_level_o}, 8'd1, "R5 higher level chosen");
    ack_first();
    chk(isr_o, 8'h0A, "R2 nested in service");
    cmd(3'b001, 3'd0);
    chk(isr_o, 8'h08, "R6 non-specific eoi takes highest");
    cmd(3'b011, 3'd3);
    chk(isr_o, 8'h00, "R6 specific eoi level 3");

    // R9 special mask mode
    irq_lvl(8'h08);
    ack_first();
    irq_lvl(8'h28);
    set_mask(8'h08);
    chk({7'd0, irq_o}, 8'h00, "R9 masked in-service still blocks in normal mode");
    smm(1'b1, 1'b1);
    chk({7'd0, irq_o}, 8'h01, "R9 special mask unblocks");
    chk({5'd0, ack_level_o}, 8'd5, "R9 lower level wins");
    smm(1'b0, 1'b1);
    chk({7'd0, irq_o}, 8'h01, "R9 enable low has no effect");
    smm(1'b1, 1'b0);
    chk({7'd0, irq_o}, 8'h00, "R9 special mask off");
    cmd(3'b011, 3'd3);
    set_mask(8'h00);
    irq_lvl(8'h00);

    // R7 rotation
    irq_lvl(8'h04);
    ack_first();
    cmd(3'b101, 3'd0);
    chk(isr_o, 8'h00, "R7 rotate eoi clears");
    irq_lvl(8'hFF);
    chk({5'd0, ack_level_o}, 8'd3, "R7 rotate eoi makes 2 lowest");
    cmd(3'b111, 3'd6);
    chk({5'd0, ack_level_o}, 8'd7, "R7 rotate specific makes 6 lowest");
    cmd(3'b110, 3'd7);
    chk({5'd0, ack_level_o}, 8'd0, "R7 priority restored");

    // R8 automatic eoi
    auto_eoi_i = 1'b1;
    cmd(3'b100, 3'd0);
    irq_lvl(8'h10);
    ack_first();
    chk(isr_o, 8'h10, "R8 grant before last strobe");
    ack_last();
    chk(isr_o, 8'h00, "R8 last strobe clears");
    irq_lvl(8'hFF);
    chk({5'd0, ack_level_o}, 8'd5, "R8 rotate flag made 4 lowest");
    cmd(3'b000, 3'd0);
    ack_first();
    chk(isr_o, 8'h20, "R8 grant level 5");
    ack_last();
    chk(isr_o, 8'h00, "R8 clear level 5");
    chk({5'd0, ack_level_o}, 8'd5, "R8 no rotation after flag cleared");

    // R10 no-op
    auto_eoi_i = 1'b0;
    ack_first();
    cmd(3'b010, 3'd5);
    chk(isr_o, 8'h20, "R10 no-op keeps in-service");
    chk({5'd0, ack_level_o}, 8'd5, "R10 no-op keeps order");
    chk({7'd0, irq_o}, 8'h00, "R5 served level blocks itself");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule